// File: doc/BRIEF.md
# USB Peripheral Suspend and Wakeup Sequencer

This block sequences power management for a full-speed USB peripheral. It watches the D+/D- line state and counts microsecond ticks while the bus rests in the J state. After a long enough quiet period it raises a suspend interrupt flag. The flag reaches the active-low interrupt pin only when both its own enable and the global enable are set. The block never powers down on its own. Software answers the suspend interrupt by writing a power-down command, and only then does the oscillator enable drop.

While powered down, the block keeps the interrupt pin at its current level. It watches the bus and a serial-port activity strobe. The first sign of traffic (a K or SE0 state on the bus, or a strobe from the serial port) turns the oscillator back on and starts a lock-wait count. When that count expires, the block raises an oscillator-ready flag. The same lock wait also runs once after reset.

The block runs on an always-on low-rate clock with a 1 MHz tick enable. Inputs arrive already synchronised to that clock. The analog oscillator and PLL are outside the block.

Top module: `usbpm_suspend_ctrl`

## Requirements
- R1: After reset, osc_en is 1, pwr_down is 0, both flags are 0 and int_n is 1, and a lock wait is in progress.
- R2: The suspend flag (flag bit 0) sets on the IDLE_TICKS-th tick counted while the bus is continuously in J (bus_dp=1, bus_dm=0), and not on any earlier tick.
- R3: Any clock edge that sees SE0 (dp=0, dm=0) or K (dp=0, dm=1) on the bus restarts the idle count from zero.
- R4: The suspend flag is raised at most once per unbroken idle stretch. Clearing it while the bus stays idle does not cause it to rise again.
- R5: Flags are cleared by writing 1 to their bit at register address 0 (bit 0 suspend, bit 1 oscillator-ready). Writing 0 to a bit leaves that flag unchanged.
- R6: int_n is 0 exactly when the global enable (address 2, bit 0) is 1 and some flag is set whose enable at address 1 is 1 (bit 0 suspend, bit 1 oscillator-ready).
- R7: Power-down never follows the idle timeout by itself. It starts only on a write of 1 to address 2 bit 1 while running. From the next cycle, osc_en is 0 and pwr_down is 1.
- R8: During power-down, int_n keeps the level set by the flags and enables.
- R9: In power-down, a K or SE0 on the bus, or a cycle with spi_active high, ends power-down. In the next cycle osc_en is 1 and pwr_down is 0. The oscillator-ready flag (bit 1) sets on the LOCK_TICKS-th tick after that, and not before.
- R10: A power-down command written during a lock wait is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle 1 MHz time-base enable |
| bus_dp | input | 1 | Synchronised D+ level |
| bus_dm | input | 1 | Synchronised D- level |
| spi_active | input | 1 | Serial-port traffic strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| osc_en | output | 1 | Oscillator enable |
| pwr_down | output | 1 | Power-down state indicator |
| irq_flags | output | 2 | Flags: bit 0 suspend, bit 1 oscillator-ready |
| int_n | output | 1 | Level, active-low interrupt |

## Verification
The bench sweeps the point at which bus activity breaks an idle stretch, for both SE0 and K. A design with an off-by-one in the terminal count, or one that ignores one of the two non-J states, would raise the suspend flag a tick early or late. With the bus still idle, it clears the flag and keeps ticking, which catches a timer that re-arms and floods software with suspend interrupts. It walks every combination of the enable bits and the global enable against known flag states, and it holds power-down with the interrupt asserted. A gating or hold error would show as a wrong or dropped int_n. It wakes the block by each of the three wake sources, counts the lock wait exactly, and issues a power-down during a lock wait. A block that entered power-down then would cut the oscillator before it locked.

// File: rtl/usbpm_pkg.sv
package usbpm_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_FLAGS = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_ENAB  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd2;

    localparam int CTRL_GIE_BIT = 0;
    localparam int CTRL_PD_BIT  = 1;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        PS_LOCK = 2'd0,
        PS_RUN  = 2'd1,
        PS_DOWN = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic oscok;
        logic susp;
    } irq_vec_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } reg_wr_t;

    function automatic line_e decode_line(input logic dp, input logic dm);
        return line_e'({dp, dm});
    endfunction

    function automatic irq_vec_t data_to_irq(input logic [REG_DW-1:0] d);
        irq_vec_t v;
        v.susp  = d[0];
        v.oscok = d[1];
        return v;
    endfunction

endpackage

// File: rtl/usbpm_idle_timer.sv
module usbpm_idle_timer
    import usbpm_pkg::*;
#(
    parameter int IDLE_TICKS = 3000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  line_e line,
    output logic  idle_hit,
    output logic  bus_act
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);
    localparam logic [CW-1:0] TERM = CW'(IDLE_TICKS);

    logic [CW-1:0] cnt_q;

    assign bus_act  = (line != LN_J);
    assign idle_hit = !bus_act && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (bus_act) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != TERM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TERM); // R2
    AST_ACT_RESTART: assert property (@(posedge clk) disable iff (rst)
        bus_act |=> cnt_q == '0); // R3
    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        idle_hit |=> !idle_hit); // R4

endmodule

// File: rtl/usbpm_power_seq.sv
module usbpm_power_seq
    import usbpm_pkg::*;
#(
    parameter int LOCK_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bus_act,
    input  logic spi_active,
    input  logic pd_req,
    output logic osc_en,
    output logic pwr_down,
    output logic lock_done
);
    localparam int LW = $clog2(LOCK_TICKS + 1);
    localparam logic [LW-1:0] LAST = LW'(LOCK_TICKS - 1);

    pwr_state_e    state_q;
    logic [LW-1:0] lcnt_q;
    logic          wake;

    assign wake      = bus_act || spi_active;
    assign lock_done = (state_q == PS_LOCK) && tick && (lcnt_q == LAST);
    assign osc_en    = (state_q != PS_DOWN);
    assign pwr_down  = (state_q == PS_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_LOCK;
            lcnt_q  <= '0;
        end else begin
            unique case (state_q)
                PS_LOCK: begin
                    if (lock_done) begin
                        state_q <= PS_RUN;
                        lcnt_q  <= '0;
                    end else if (tick) begin
                        lcnt_q <= lcnt_q + 1'b1;
                    end
                end
                PS_RUN: begin
                    if (pd_req) state_q <= PS_DOWN;
                end
                PS_DOWN: begin
                    if (wake) begin
                        state_q <= PS_LOCK;
                        lcnt_q  <= '0;
                    end
                end
                default: begin
                    state_q <= PS_LOCK;
                    lcnt_q  <= '0;
                end
            endcase
        end
    end

    AST_NO_AUTO_DOWN: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && !pd_req) |=> !pwr_down); // R7
    AST_WAKE_OSC: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && wake) |=> osc_en && lcnt_q == '0); // R9
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_LOCK && !lock_done) |=> state_q == PS_LOCK); // R10

endmodule

// File: rtl/usbpm_irq_regs.sv
module usbpm_irq_regs
    import usbpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    input  irq_vec_t set_vec,
    output irq_vec_t flags,
    output logic     pd_req,
    output logic     int_n
);
    irq_vec_t flags_q;
    irq_vec_t en_q;
    logic     gie_q;
    irq_vec_t clr_vec;

    assign clr_vec = (wr.en && wr.addr == ADDR_FLAGS) ? data_to_irq(wr.data) : '0;
    assign pd_req  = wr.en && (wr.addr == ADDR_CTRL) && wr.data[CTRL_PD_BIT];
    assign flags   = flags_q;
    assign int_n   = !(gie_q && |(flags_q & en_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            en_q    <= '0;
            gie_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (wr.en && wr.addr == ADDR_ENAB) en_q <= data_to_irq(wr.data);
            if (wr.en && wr.addr == ADDR_CTRL) gie_q <= wr.data[CTRL_GIE_BIT];
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags_q.susp && !clr_vec.susp) |=> flags_q.susp); // R5
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        set_vec.oscok |=> flags_q.oscok); // R9
    AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> (flags_q != '0)); // R6

endmodule

// File: rtl/usbpm_suspend_ctrl.sv
module usbpm_suspend_ctrl
    import usbpm_pkg::*;
#(
    parameter int IDLE_TICKS = 3000,
    parameter int LOCK_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1us,
    input  logic              bus_dp,
    input  logic              bus_dm,
    input  logic              spi_active,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [REG_DW-1:0] reg_wr_data,
    output logic              osc_en,
    output logic              pwr_down,
    output logic [1:0]        irq_flags,
    output logic              int_n
);
    line_e    line;
    logic     idle_hit;
    logic     bus_act;
    logic     pd_req;
    logic     lock_done;
    reg_wr_t  wr;
    irq_vec_t set_vec;
    irq_vec_t flags;

    assign line          = decode_line(bus_dp, bus_dm);
    assign wr.en         = reg_wr_en;
    assign wr.addr       = reg_wr_addr;
    assign wr.data       = reg_wr_data;
    assign set_vec.susp  = idle_hit;
    assign set_vec.oscok = lock_done;
    assign irq_flags     = flags;

    usbpm_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1us),
        .line     (line),
        .idle_hit (idle_hit),
        .bus_act  (bus_act)
    );

    usbpm_power_seq #(.LOCK_TICKS(LOCK_TICKS)) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_1us),
        .bus_act    (bus_act),
        .spi_active (spi_active),
        .pd_req     (pd_req),
        .osc_en     (osc_en),
        .pwr_down   (pwr_down),
        .lock_done  (lock_done)
    );

    usbpm_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .set_vec (set_vec),
        .flags   (flags),
        .pd_req  (pd_req),
        .int_n   (int_n)
    );

    AST_DOWN_HOLDS_INT: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_down) && pwr_down && !reg_wr_en && !$past(reg_wr_en)) |-> $stable(int_n)); // R8

endmodule

// File: tb/usbpm_suspend_ctrl_bench.sv
`timescale 1ns/1ps
module usbpm_suspend_ctrl_bench;
    localparam int IDLE = 40;
    localparam int LOCK = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic       spi = 1'b0;
    logic       wen = 1'b0;
    logic [1:0] waddr = '0;
    logic [7:0] wdata = '0;
    logic       osc_en, pwr_down, int_n;
    logic [1:0] flags;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    usbpm_suspend_ctrl #(.IDLE_TICKS(IDLE), .LOCK_TICKS(LOCK)) u_usbpm_suspend_ctrl (
        .clk(clk), .rst(rst), .tick_1us(tick), .bus_dp(dp), .bus_dm(dm),
        .spi_active(spi), .reg_wr_en(wen), .reg_wr_addr(waddr), .reg_wr_data(wdata),
        .osc_en(osc_en), .pwr_down(pwr_down), .irq_flags(flags), .int_n(int_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        waddr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic set_line(input int kind); // 0 SE0, 1 K, 2 J
        case (kind)
            0: begin dp = 1'b0; dm = 1'b0; end
            1: begin dp = 1'b0; dm = 1'b1; end
            default: begin dp = 1'b1; dm = 1'b0; end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_line(0);
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 osc_en", osc_en, 1);
        check("R1 pwr_down", pwr_down, 0);
        check("R1 flags", flags, 0);
        check("R1 int_n", int_n, 1);

        wr(2, 8'h02);
        check("R10 osc_en", osc_en, 1);
        check("R10 pwr_down", pwr_down, 0);
        ticks(LOCK - 1);
        check("R1 lock not yet", flags, 0);
        ticks(1);
        check("R1 lock done", flags, 2);
        check("R10 still up", pwr_down, 0);

        wr(0, 8'h00);
        check("R5 write 0", flags, 2);
        wr(0, 8'h02);
        check("R5 clear", flags, 0);

        for (int kind = 0; kind < 2; kind++) begin
            for (int k = 0; k < IDLE; k += 13) begin
                set_line(2);
                ticks(k);
                check("R3 mid idle", flags, 0);
                set_line(kind);
                step(1);
                set_line(2);
                ticks(IDLE - 1);
                check("R3 restart", flags, 0);
                ticks(1);
                check("R2 terminal", flags, 1);
                wr(0, 8'h01);
                check("R5 clear susp", flags, 0);
            end
        end

        ticks(IDLE + 5);
        check("R4 no re-raise", flags, 0);

        set_line(0);
        step(1);
        set_line(2);
        ticks(IDLE);
        check("R2 fresh idle", flags, 1);
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 4; e++) begin
                wr(1, 8'(e));
                wr(2, 8'(g));
                check("R6 gate susp", int_n, (g == 1 && e[0]) ? 0 : 1);
            end
        end

        wr(1, 8'h01);
        wr(2, 8'h01);
        step(50);
        check("R7 no auto down", osc_en, 1);
        check("R7 no auto pd", pwr_down, 0);

        for (int src = 0; src < 3; src++) begin
            wr(2, 8'h03);
            check("R7 osc off", osc_en, 0);
            check("R7 pd set", pwr_down, 1);
            for (int i = 0; i < 5; i++) begin
                ticks(3);
                check("R8 int held", int_n, 0);
            end
            check("R8 still down", pwr_down, 1);
            if (src == 0) spi = 1'b1; else set_line(src - 1);
            step(1);
            spi = 1'b0;
            set_line(2);
            check("R9 osc back", osc_en, 1);
            check("R9 pd clear", pwr_down, 0);
            ticks(LOCK - 1);
            check("R9 lock wait", flags[1], 0);
            ticks(1);
            check("R9 oscok", flags[1], 1);
            if (src == 0) begin
                for (int g = 0; g < 2; g++) begin
                    for (int e = 0; e < 4; e++) begin
                        wr(1, 8'(e));
                        wr(2, 8'(g));
                        check("R6 gate both", int_n, (g == 1 && e != 0) ? 0 : 1);
                    end
                end
                wr(1, 8'h01);
                wr(2, 8'h01);
            end
            wr(0, 8'h02);
            check("R5 clear oscok", flags, 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule